// File: doc/BRIEF.md
# Silence-Delimited Serial Frame Receiver with Station Filter

This block sits behind a byte-level UART receiver on a shared half-duplex bus. It measures how long the line stays quiet after each byte, counting baud ticks. A gap of three and a half character times ends a frame. A shorter but still long pause inside a frame spoils that frame.

The first byte of each frame is compared against the configured station number as soon as it lands. A frame for another station is ignored byte by byte until the next long silence. Frames for this station are streamed out with a start marker as their bytes arrive. When the closing silence is seen, a one-cycle verdict tells the consumer whether to keep or drop what it received. The verdict depends on the trailing CRC, the frame length, framing errors and inter-byte gaps.

Three saturating counters tally good frames, checksum failures and framing errors. They are meant for tuning bus turnaround delays.

Top module: `rtu_frame_rx`

## Requirements
- R1: A frame ends once the line has been idle for T35 = (7*TPC+1)/2 baud ticks after its last byte (39 with TPC=11). The verdict `frm_done` pulses high for one cycle, on the clock after the edge that delivers that tick. A byte that arrives after only T35-1 ticks stays in the same frame.
- R2: When the first byte of a frame equals `station_addr`, every byte of the frame is forwarded on `out_data` with `out_valid` one cycle after its `rx_valid`. `out_sof` is high only with the first byte.
- R3: When the first byte matches neither the station nor broadcast, no byte is forwarded and no `frm_done` is produced for that frame. The receiver is ready for a new frame after the closing silence.
- R4: `frm_good` is high with `frm_done` only if the CRC-16 over every byte of the frame leaves a zero residue. The CRC uses reflected polynomial 0xA001 and start value 0xFFFF, and its check bytes are sent low byte first.
- R5: A frame of fewer than 4 bytes is reported bad even if its CRC residue is zero.
- R6: A byte received with `rx_ferr` high makes its frame bad. Every such byte, in any frame, adds one to `cnt_ferr`.
- R7: A byte that follows the previous byte of the same frame after T15 = (3*TPC+1)/2 ticks or more (17 with TPC=11) marks the frame bad. A gap of T15-1 ticks does not.
- R8: `cnt_good` counts frames reported good. `cnt_crc` counts frames that were accepted by address, have at least 4 bytes and leave a nonzero residue. Both change on the same clock as `frm_done`.
- R9: All counters stop at 2^CNT_W-1. A high `clr_stats` zeroes them on the next clock and takes priority over any increment.
- R10: Address 0 is broadcast and is accepted like a matching address.
- R11: After reset, all outputs and counters are zero and the line counts as idle, so the first byte starts a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_stats | input | 1 | Synchronous clear of all counters |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_ferr | input | 1 | Framing error on the strobed byte |
| station_addr | input | 8 | This station's number |
| out_valid | output | 1 | Forwarded byte strobe |
| out_data | output | 8 | Forwarded byte |
| out_sof | output | 1 | First byte of an accepted frame |
| frm_done | output | 1 | Frame verdict strobe |
| frm_good | output | 1 | Verdict: keep the frame |
| cnt_good | output | CNT_W | Good-frame count |
| cnt_crc | output | CNT_W | Checksum-failure count |
| cnt_ferr | output | CNT_W | Framing-error byte count |

## Verification
The bench probes the timing edges exactly, using gaps of 16 against 17 ticks and 38 against 39 ticks. A timer that is off by one would either split a frame early or pass a slow byte as good. It sends a 3-byte frame with a valid residue, which a design that skips the length check would wrongly accept. It mixes foreign, broadcast and own-address frames with corrupt check bytes: a filter that ran late would leak foreign bytes, and a checksum counter that is not gated by address would count traffic meant for other stations. Counters are narrowed to three bits so that saturation and clearing are reached, and a wrapping counter would read zero after eight events.

// File: rtl/rtu_rx_pkg.sv
package rtu_rx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RECV = 2'd1,
      ST_SKIP = 2'd2
   } rx_state_e;

   // one byte through a reflected CRC-16
   function automatic logic [15:0] crc16_byte(input logic [15:0] cur,
                                              input logic [7:0]  din,
                                              input logic [15:0] poly);
      logic [15:0] r;
      r = cur ^ {8'h00, din};
      for (int b = 0; b < 8; b++) begin
         r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/rtu_gap_timer.sv
module rtu_gap_timer #(
   parameter int TPC = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic byte_in,
   output logic gap_mid,
   output logic gap_end
);
   localparam int T15 = (3 * TPC + 1) / 2;
   localparam int T35 = (7 * TPC + 1) / 2;
   localparam int CW  = $clog2(T35 + 1);

   logic [CW-1:0] sil_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sil_q <= CW'(T35);
      else if (byte_in)
         sil_q <= '0;
      else if (tick && sil_q != CW'(T35))
         sil_q <= sil_q + 1'b1;
   end

   assign gap_mid = (sil_q >= CW'(T15));
   assign gap_end = tick && !byte_in && (sil_q == CW'(T35 - 1));

   p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_in |=> (sil_q == '0));

   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sil_q == CW'(T35) && !byte_in) |=> (sil_q == CW'(T35)));

endmodule

// File: rtl/rtu_crc16.sv
module rtu_crc16 #(
   parameter logic [15:0] POLY = 16'hA001,
   parameter logic [15:0] INIT = 16'hFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        upd,
   input  logic [7:0]  din,
   output logic [15:0] crc
);
   import rtu_rx_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n)
         crc <= INIT;
      else if (start)
         crc <= crc16_byte(INIT, din, POLY);
      else if (upd)
         crc <= crc16_byte(crc, din, POLY);
   end

   p_crc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !upd) |=> $stable(crc));

endmodule

// File: rtl/rtu_sat_ctr.sv
module rtu_sat_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc && cnt != MAXV)
         cnt <= cnt + 1'b1;
   end

   p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == MAXV && !clr) |=> (cnt == MAXV));

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

endmodule

// File: rtl/rtu_frame_rx.sv
module rtu_frame_rx #(
   parameter int          TPC      = 11,
   parameter int          MIN_LEN  = 4,
   parameter int          CNT_W    = 16,
   parameter bit          BCAST_EN = 1'b1,
   parameter logic [15:0] CRC_POLY = 16'hA001,
   parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_stats,
   input  logic             baud_tick,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   input  logic             rx_ferr,
   input  logic [7:0]       station_addr,
   output logic             out_valid,
   output logic [7:0]       out_data,
   output logic             out_sof,
   output logic             frm_done,
   output logic             frm_good,
   output logic [CNT_W-1:0] cnt_good,
   output logic [CNT_W-1:0] cnt_crc,
   output logic [CNT_W-1:0] cnt_ferr
);
   import rtu_rx_pkg::*;

   localparam int LW   = $clog2(MIN_LEN + 1);
   localparam int NCNT = 3;

   if (TPC < 2) begin : g_bad_tpc
      $error("rtu_frame_rx: TPC must be at least 2");
   end
   if (MIN_LEN < 3) begin : g_bad_len
      $error("rtu_frame_rx: MIN_LEN must cover address and check bytes");
   end
   if (CNT_W < 2) begin : g_bad_cw
      $error("rtu_frame_rx: CNT_W must be at least 2");
   end

   rx_state_e   state_q;
   logic        bad_q;
   logic [LW-1:0] len_q;
   logic [15:0] crc_q;
   logic        gap_mid, gap_end;
   logic        addr_hit;
   logic        crc_start, crc_upd, fin, len_ok, fin_good;
   logic [NCNT-1:0] inc_v;
   logic [CNT_W-1:0] cnt_v [NCNT];

   // station match, broadcast optional
   if (BCAST_EN) begin : g_bcast
      assign addr_hit = (rx_data == station_addr) || (rx_data == 8'h00);
   end else begin : g_nobcast
      assign addr_hit = (rx_data == station_addr);
   end

   rtu_gap_timer #(.TPC(TPC)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (baud_tick),
      .byte_in (rx_valid),
      .gap_mid (gap_mid),
      .gap_end (gap_end)
   );

   rtu_crc16 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .start (crc_start),
      .upd   (crc_upd),
      .din   (rx_data),
      .crc   (crc_q)
   );

   always_comb begin
      crc_start = rx_valid && (state_q == ST_IDLE) && addr_hit;
      crc_upd   = rx_valid && (state_q == ST_RECV);
      fin       = gap_end && (state_q == ST_RECV);
      len_ok    = (len_q >= LW'(MIN_LEN));
      fin_good  = fin && !bad_q && len_ok && (crc_q == 16'h0000);
      inc_v[0]  = fin_good;
      inc_v[1]  = fin && len_ok && (crc_q != 16'h0000);
      inc_v[2]  = rx_valid && rx_ferr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         bad_q     <= 1'b0;
         len_q     <= '0;
         out_valid <= 1'b0;
         out_data  <= 8'h00;
         out_sof   <= 1'b0;
         frm_done  <= 1'b0;
         frm_good  <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         frm_done  <= 1'b0;
         frm_good  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (rx_valid) begin
                  if (addr_hit) begin
                     state_q   <= ST_RECV;
                     bad_q     <= rx_ferr;
                     len_q     <= LW'(1);
                     out_valid <= 1'b1;
                     out_sof   <= 1'b1;
                     out_data  <= rx_data;
                  end else begin
                     state_q <= ST_SKIP;
                  end
               end
            end
            ST_RECV: begin
               if (rx_valid) begin
                  if (rx_ferr || gap_mid)
                     bad_q <= 1'b1;
                  if (len_q < LW'(MIN_LEN))
                     len_q <= len_q + 1'b1;
                  out_valid <= 1'b1;
                  out_data  <= rx_data;
               end else if (gap_end) begin
                  state_q  <= ST_IDLE;
                  frm_done <= 1'b1;
                  frm_good <= fin_good;
               end
            end
            ST_SKIP: begin
               if (gap_end)
                  state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < NCNT; g++) begin : g_ctr
      rtu_sat_ctr #(.W(CNT_W)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr_stats),
         .inc   (inc_v[g]),
         .cnt   (cnt_v[g])
      );
   end

   assign cnt_good = cnt_v[0];
   assign cnt_crc  = cnt_v[1];
   assign cnt_ferr = cnt_v[2];

   p_sof_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid);

   p_skip_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP && rx_valid) |=> !out_valid);

   p_done_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done |-> $past(gap_end));

   p_good_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_done && frm_good) |-> (len_q >= LW'(MIN_LEN)));

   p_good_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frm_good |-> frm_done);

endmodule

// File: tb/rtu_frame_rx_tb.sv
module rtu_frame_rx_tb_top;

   localparam int   TPC     = 11;
   localparam int   CW      = 3;
   localparam int   MAXC    = 7;
   localparam int   T15     = 17;
   localparam int   T35     = 39;
   localparam logic [7:0] STATION = 8'h2A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr_stats = 1'b0;
   logic       baud_tick = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       rx_ferr = 1'b0;
   logic       out_valid, out_sof, frm_done, frm_good;
   logic [7:0] out_data;
   logic [CW-1:0] cnt_good, cnt_crc, cnt_ferr;

   always #5 clk = ~clk;

   rtu_frame_rx #(.TPC(TPC), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .clr_stats(clr_stats), .baud_tick(baud_tick),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr),
      .station_addr(STATION), .out_valid(out_valid), .out_data(out_data),
      .out_sof(out_sof), .frm_done(frm_done), .frm_good(frm_good),
      .cnt_good(cnt_good), .cnt_crc(cnt_crc), .cnt_ferr(cnt_ferr)
   );

   int total = 0;
   int bad   = 0;
   logic [7:0] fb [0:15];
   logic       ff [0:15];
   logic [7:0] ob [0:31];
   logic       os [0:31];
   int ocnt  = 0;
   int ndone = 0;
   logic last_good = 1'b0;
   int m_good = 0, m_crc = 0, m_ferr = 0;

   always @(negedge clk) begin
      if (out_valid && ocnt < 32) begin
         ob[ocnt] = out_data;
         os[ocnt] = out_sof;
         ocnt++;
      end
      if (frm_done) begin
         ndone++;
         last_good = frm_good;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int sat(input int v);
      return (v > MAXC) ? MAXC : v;
   endfunction

   function automatic logic [15:0] ref_crc(input int n);
      logic [15:0] c = 16'hFFFF;
      for (int i = 0; i < n; i++) begin
         c = c ^ {8'h00, fb[i]};
         for (int k = 0; k < 8; k++) begin
            if (c[0]) c = (c >> 1) ^ 16'hA001;
            else      c = c >> 1;
         end
      end
      return c;
   endfunction

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) baud_tick = 1'b1;
         @(negedge clk) baud_tick = 1'b0;
      end
   endtask

   task automatic put_byte(input logic [7:0] d, input logic fe);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = d; rx_ferr = fe;
      @(negedge clk);
      rx_valid = 1'b0; rx_ferr = 1'b0;
   endtask

   // append the check bytes after k bytes, low byte first
   task automatic add_crc(input int k);
      logic [15:0] c;
      c = ref_crc(k);
      fb[k] = c[7:0];
      fb[k+1] = c[15:8];
      ff[k] = 1'b0;
      ff[k+1] = 1'b0;
   endtask

   // send n bytes; gap 5 ticks, except 'gap' ticks before byte gpos
   task automatic run_frame(input int n, input int gap, input int gpos);
      bit match, anyf, exp_good, all_eq;
      int nsof;
      ocnt = 0; ndone = 0;
      for (int i = 0; i < n; i++) begin
         if (i > 0) ticks((i == gpos) ? gap : 5);
         put_byte(fb[i], ff[i]);
      end
      ticks(T35 + 6);
      repeat (3) @(negedge clk);
      match = (fb[0] == STATION) || (fb[0] == 8'h00);
      anyf = 1'b0;
      for (int i = 0; i < n; i++) if (ff[i]) anyf = 1'b1;
      exp_good = match && !anyf && n >= 4 && ref_crc(n) == 16'h0 &&
                 !(gpos >= 1 && gpos < n && gap >= T15);
      for (int i = 0; i < n; i++) if (ff[i]) m_ferr++;
      if (match && n >= 4 && ref_crc(n) != 16'h0) m_crc++;
      if (exp_good) m_good++;
      if (match) begin
         chk(ndone == 1, "R1 one verdict per frame", ndone, 1);
         chk(last_good == exp_good, "R4 verdict", last_good, exp_good);
         chk(ocnt == n, "R2 forwarded byte count", ocnt, n);
         all_eq = 1'b1; nsof = 0;
         for (int i = 0; i < n && i < 32; i++) begin
            if (ob[i] != fb[i]) all_eq = 1'b0;
            if (os[i]) nsof++;
         end
         chk(all_eq, "R2 forwarded bytes", all_eq, 1);
         chk(nsof == 1 && os[0], "R2 start marker", nsof, 1);
      end else begin
         chk(ndone == 0, "R3 no verdict for foreign frame", ndone, 0);
         chk(ocnt == 0, "R3 no bytes from foreign frame", ocnt, 0);
      end
      chk(int'(cnt_good) == sat(m_good), "R8 good counter", cnt_good, sat(m_good));
      chk(int'(cnt_crc) == sat(m_crc), "R8 crc counter", cnt_crc, sat(m_crc));
      chk(int'(cnt_ferr) == sat(m_ferr), "R6 ferr counter", cnt_ferr, sat(m_ferr));
   endtask

   task automatic clear_stats();
      @(negedge clk) clr_stats = 1'b1;
      @(negedge clk) clr_stats = 1'b0;
      m_good = 0; m_crc = 0; m_ferr = 0;
      chk(cnt_good == 0 && cnt_crc == 0 && cnt_ferr == 0, "R9 clear", cnt_good, 0);
   endtask

   task automatic good_frame(input logic [7:0] adr);
      fb[0] = adr; fb[1] = 8'h03; ff[0] = 0; ff[1] = 0;
      add_crc(2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n, k, sel;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk(!out_valid && !out_sof && !frm_done && !frm_good, "R11 outputs idle", out_valid, 0);
      chk(cnt_good == 0 && cnt_crc == 0 && cnt_ferr == 0, "R11 counters zero", cnt_good, 0);

      // R2 R4: own address good frame
      good_frame(STATION); run_frame(4, 0, 0);
      // R10: broadcast
      good_frame(8'h00); run_frame(4, 0, 0);
      // R3: foreign with bad check bytes
      good_frame(8'h31); fb[3] = fb[3] ^ 8'h01; run_frame(4, 0, 0);
      // R4: corrupted own frame
      good_frame(STATION); fb[1] = 8'h04; run_frame(4, 0, 0);
      // R5: 3-byte frame with valid residue
      fb[0] = STATION; ff[0] = 0; add_crc(1); run_frame(3, 0, 0);
      // R6: framing error
      good_frame(STATION); ff[2] = 1'b1; run_frame(4, 0, 0);
      // R7: gap T15-1 good, gap T15 bad
      good_frame(STATION); run_frame(4, T15 - 1, 2);
      chk(last_good == 1'b1, "R7 gap T15-1 keeps frame", last_good, 1);
      good_frame(STATION); run_frame(4, T15, 2);
      chk(last_good == 1'b0, "R7 gap T15 spoils frame", last_good, 0);
      // R1: gap T35-1 keeps one frame
      good_frame(STATION); run_frame(4, T35 - 1, 3);
      chk(ndone == 1, "R1 gap T35-1 single frame", ndone, 1);
      // R1: gap T35 splits; second part foreign
      ocnt = 0; ndone = 0;
      put_byte(STATION, 1'b0);
      ticks(T35);
      put_byte(8'h55, 1'b0);
      ticks(T35 + 6);
      repeat (3) @(negedge clk);
      chk(ndone == 1 && last_good == 1'b0, "R1 gap T35 ends frame", ndone, 1);
      chk(ocnt == 1, "R1 gap T35 second byte not forwarded", ocnt, 1);

      // R9: saturation then clear
      clear_stats();
      for (int i = 0; i < 9; i++) begin good_frame(STATION); run_frame(4, 0, 0); end
      chk(int'(cnt_good) == MAXC, "R9 saturation", cnt_good, MAXC);
      clear_stats();

      // random mix
      void'($urandom(32'd20240611));
      for (int t = 0; t < 60; t++) begin
         sel = $urandom_range(0, 9);
         fb[0] = (sel < 5) ? STATION : (sel < 7) ? 8'h00 : 8'($urandom_range(1, 255));
         ff[0] = 1'b0;
         k = $urandom_range(0, 4);
         for (int i = 1; i <= k; i++) begin
            fb[i] = 8'($urandom_range(0, 255)); ff[i] = 1'b0;
         end
         n = k + 1;
         if ($urandom_range(0, 3) != 0) begin add_crc(n); n = n + 2; end
         if ($urandom_range(0, 5) == 0) fb[$urandom_range(1, n - 1)] ^= 8'h10;
         if ($urandom_range(0, 9) == 0) ff[$urandom_range(0, n - 1)] = 1'b1;
         if ($urandom_range(0, 4) == 0)
            run_frame(n, $urandom_range(6, 30), $urandom_range(1, 6));
         else
            run_frame(n, 0, 0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule